// File: doc/BRIEF.md
# Synchronous-Read Unified Memory

A byte-addressed 4 KB store for a 32-bit RISC-V core. It can serve either as instruction memory or as data memory. The core presents an address, an access size and a read/write strobe. Read data comes back from a register one clock later, so the storage can sit in FPGA block RAM. An enable input lets the fetch stage freeze the read output while the pipeline stalls.

Byte, halfword and word accesses are all supported at any byte offset. Multi-byte accesses may straddle a word boundary, and they may also run past the top of the array and wrap to its start. The byte at the lowest address always lands in the least significant bits of the data. The core's addresses are taken relative to the code base `0x0100_0000`, and only the low 12 bits of that offset select a byte. A separate byte-wide preload port fills the array before the core starts running.

The storage is split into four byte lanes, one per address residue modulo 4. Each lane is its own simple one-port-read, one-port-write array. This is why an unaligned word needs only one access per lane.

Top module: `sync_uram`

## Requirements
- R1: Read data reflects the address, size and signedness sampled at the clock edge where `en` is high. It appears after that edge, and changing the inputs between edges never changes `rdata`.
- R2: The byte selected is `(addr - 0x0100_0000) mod 4096`. Address bits above that range have no effect.
- R3: While `en` is low, `rdata` keeps its previous value. Core writes and preload writes are still performed.
- R4: `size` encodes the access width: 00 is one byte, 01 is two bytes and 10 is four bytes. 11 acts as 10. The byte at offset i of the access occupies `rdata`/`wdata` bits 8i+7 down to 8i.
- R5: Halfword and word accesses at any byte offset read or write the consecutive bytes. This holds across word boundaries and also across the wrap from byte 4095 to byte 0.
- R6: Byte and halfword reads are zero-extended when `rd_unsigned` is 1 and sign-extended from their top bit when it is 0.
- R7: A write of width n changes exactly the n addressed bytes. Every other byte keeps its contents.
- R8: When `ld_we` is high, `ld_byte` is written at byte `(ld_addr - 0x0100_0000) mod 4096`. A core write in the same cycle is dropped, but a core read in that cycle still takes place.
- R9: A read and a write to the same bytes in one cycle return the contents as they were before the write.
- R10: After reset, `rdata` is zero until the first enabled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read-output registers |
| en | input | 1 | Read enable; low holds `rdata` |
| addr | input | 32 | Core byte address |
| wr_en | input | 1 | Core write strobe |
| size | input | 2 | Access width code |
| rd_unsigned | input | 1 | 1 for zero extension of sub-word reads |
| wdata | input | 32 | Core write data, low byte first |
| rdata | output | 32 | Registered read data |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | 32 | Preload byte address |
| ld_byte | input | 8 | Preload data byte |

## Verification
On every cycle, the embedded assertions check that `rdata` holds while `en` is low. They also check that every sub-word read returns upper bits matching its signedness: all zero, or copies of the top data bit. Which bytes are returned, whether partial writes spare their neighbours, the wrap at the top of the array, read-before-write ordering and the preload priority all depend on stored history. The bench shows these against a byte-array model, through random mixed traffic and directed corner cases.

// File: rtl/sync_uram.sv
module sync_uram #(
  parameter int ADDR_W = 32,
  parameter int DEPTH = 4096,
  parameter logic [ADDR_W-1:0] BASE = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        size,
  input  logic              rd_unsigned,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_byte
);
  localparam int OFF_W = $clog2(DEPTH);
  localparam int WORDS = DEPTH / 4;

  logic [ADDR_W-1:0] a_rel, l_rel;
  logic [OFF_W-1:0]  a_off, l_off, w_off;
  logic [2:0]        nb, w_nb;
  logic [31:0]       w_data, lanes, rot;
  logic [63:0]       rot2;
  logic              w_go;
  logic [1:0]        q_off, q_size;
  logic              q_uns;

  assign a_rel  = addr - BASE;
  assign l_rel  = ld_addr - BASE;
  assign a_off  = a_rel[OFF_W-1:0];
  assign l_off  = l_rel[OFF_W-1:0];
  assign nb     = (size == 2'b00) ? 3'd1 : (size == 2'b01) ? 3'd2 : 3'd4;
  assign w_go   = ld_we | wr_en;
  assign w_off  = ld_we ? l_off : a_off;
  assign w_nb   = ld_we ? 3'd1 : nb;
  assign w_data = ld_we ? {24'b0, ld_byte} : wdata;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [1:0]       rj, wj;
    logic [OFF_W-1:0] rsum, wsum;
    logic             whit;
    logic [7:0]       q;
    logic [7:0]       bank [WORDS];

    assign rj   = 2'(k) - a_off[1:0];
    assign wj   = 2'(k) - w_off[1:0];
    assign rsum = a_off + OFF_W'(rj);
    assign wsum = w_off + OFF_W'(wj);
    assign whit = w_go && ({1'b0, wj} < w_nb);

    always_ff @(posedge clk)
      if (whit) bank[wsum[OFF_W-1:2]] <= w_data[{wj, 3'b000} +: 8];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  q <= '0;
      else if (en) q <= bank[rsum[OFF_W-1:2]];

    assign lanes[8*k +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_off  <= '0;
      q_size <= 2'b10;
      q_uns  <= 1'b0;
    end else if (en) begin
      q_off  <= a_off[1:0];
      q_size <= size;
      q_uns  <= rd_unsigned;
    end

  assign rot2 = {lanes, lanes} >> {q_off, 3'b000};
  assign rot  = rot2[31:0];

  always_comb
    case (q_size)
      2'b00:   rdata = {{24{~q_uns & rot[7]}}, rot[7:0]};
      2'b01:   rdata = {{16{~q_uns & rot[15]}}, rot[15:0]};
      default: rdata = rot;
    endcase

  // R3
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));

  // R6
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && size == 2'b00 && rd_unsigned |=> rdata[31:8] == 24'h0);

  // R6
  byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && size == 2'b00 && !rd_unsigned |=> $countones(rdata[31:7]) inside {0, 25});

  // R6
  half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && size == 2'b01 && rd_unsigned |=> rdata[31:16] == 16'h0);

  // R6
  half_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && size == 2'b01 && !rd_unsigned |=> $countones(rdata[31:15]) inside {0, 17});
endmodule

// File: tb/sync_uram_bench.sv
`timescale 1ns/1ps
module sync_uram_bench;
  localparam logic [31:0] BASE = 32'h0100_0000;

  logic        clk = 0, rst_n = 0, en = 0, wr_en = 0, rd_unsigned = 0, ld_we = 0;
  logic [31:0] addr = 0, wdata = 0, ld_addr = 0;
  logic [1:0]  size = 0;
  logic [7:0]  ld_byte = 0;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  logic [7:0]  model [4096];
  logic [31:0] last_exp = 0;

  always #10 clk = ~clk;

  sync_uram u_sync_uram (
    .clk(clk), .rst_n(rst_n), .en(en), .addr(addr), .wr_en(wr_en), .size(size),
    .rd_unsigned(rd_unsigned), .wdata(wdata), .rdata(rdata),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_byte(ld_byte));

  function automatic logic [11:0] offs(input logic [31:0] a);
    logic [31:0] r;
    r = a - BASE;
    return r[11:0];
  endfunction

  function automatic int width(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [11:0] o, input logic [1:0] sz, input logic u);
    logic [31:0] v;
    v = 0;
    for (int j = 0; j < width(sz); j++) v[8*j +: 8] = model[12'(o + 12'(j))];
    if (sz == 2'b00 && !u && v[7])  v[31:8]  = 24'hFF_FFFF;
    if (sz == 2'b01 && !u && v[15]) v[31:16] = 16'hFFFF;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [31:0] a, input logic we, input logic [1:0] sz, input logic u,
                    input logic [31:0] d, input logic e, input logic lw,
                    input logic [31:0] la, input logic [7:0] lb, input string tag);
    logic [31:0] nexp;
    addr = a; wr_en = we; size = sz; rd_unsigned = u; wdata = d; en = e;
    ld_we = lw; ld_addr = la; ld_byte = lb;
    nexp = e ? expect_rd(offs(a), sz, u) : last_exp;
    #1 check("R1 no combinational read", rdata, last_exp);
    @(negedge clk);
    check(tag, rdata, nexp);
    last_exp = nexp;
    if (lw) model[offs(la)] = lb;
    else if (we)
      for (int j = 0; j < width(sz); j++) model[12'(offs(a) + 12'(j))] = d[8*j +: 8];
    wr_en = 0; ld_we = 0; en = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz, input logic u, input string tag);
    op(a, 0, sz, u, 0, 1, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    op(a, 1, sz, 0, d, 1, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset value", rdata, 32'h0);

    for (int i = 0; i < 4096; i++)
      op(0, 0, 2'b10, 0, 0, 0, 1, BASE + 32'(i), 8'((i * 7 + 3) & 8'hFF), "R8 preload");
    rd(BASE + 32'h0, 2'b10, 0, "R8 R4 preload word");
    rd(BASE + 32'hFFE, 2'b10, 0, "R5 R2 wrap word");
    rd(32'hABC0_0FFF, 2'b01, 1, "R2 high bits ignored");
    rd(BASE + 32'h101, 2'b10, 0, "R5 unaligned word");
    rd(BASE + 32'h203, 2'b01, 1, "R5 halfword across words");

    wr(BASE + 32'h100, 2'b10, 32'h1122_3344, "R9 write read-first");
    wr(BASE + 32'h101, 2'b01, 32'hDEAD_BEEF, "R9 write read-first");
    rd(BASE + 32'h100, 2'b10, 0, "R7 halfword spares neighbours");
    wr(BASE + 32'h104, 2'b00, 32'h0000_0080, "R9 byte write");
    rd(BASE + 32'h104, 2'b00, 0, "R6 byte sign extend");
    rd(BASE + 32'h104, 2'b00, 1, "R6 byte zero extend");
    wr(BASE + 32'h106, 2'b01, 32'h0000_9001, "R9 half write");
    rd(BASE + 32'h106, 2'b01, 0, "R6 half sign extend");
    rd(BASE + 32'h106, 2'b11, 1, "R4 size 11 acts as word");

    rd(BASE + 32'h100, 2'b10, 0, "R3 prime");
    op(BASE + 32'h300, 0, 2'b00, 1, 0, 0, 0, 0, 0, "R3 stall holds rdata");
    op(BASE + 32'h300, 1, 2'b10, 0, 32'hCAFE_F00D, 0, 0, 0, 0, "R3 stall during write");
    rd(BASE + 32'h300, 2'b10, 0, "R3 write done under stall");

    op(BASE + 32'h400, 1, 2'b10, 0, 32'h5555_AAAA, 1, 1, BASE + 32'h500, 8'h3C, "R8 read beside preload");
    rd(BASE + 32'h400, 2'b10, 0, "R8 core write dropped");
    rd(BASE + 32'h500, 2'b00, 1, "R8 preload byte written");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      a = (n % 4 == 0) ? $urandom : BASE + ($urandom % 4096);
      op(a, ($urandom % 3) == 0, 2'($urandom), 1'($urandom), $urandom, ($urandom % 5) != 0,
         0, 0, 0, "R1 R4 R5 R7 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule